// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an external SDRAM from power-up to normal operation without any software involvement. After reset it holds the command bus at NOP for a settling time that is derived from the clock frequency. It then precharges all banks. Next it sets a short refresh interval and issues auto-refresh commands at that rate until a minimum wait has passed and enough refreshes have gone out. After that it loads the normal refresh interval, writes the device mode register, and raises a done flag.

The burst length written to the mode register depends on the memory bus width. A 32-bit bus uses burst 4, and a 16-bit bus uses burst 8. The address lines that carry the mode field shift with the width as well. The width select is captured once at the start of the sequence. The refresh-interval output feeds the refresh timer of the main memory controller once initialization has finished.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `cmd_o` is NOP (3'b111), `addr_o` and `ba_o` are 0, `refresh_interval_o` is 0 and `init_done_o` is 0.
- R2: After that first cycle, `cmd_o` stays NOP for exactly CLK_FREQ_MHZ*WAIT_US cycles.
- R3: The next cycle carries a single precharge-all command: `cmd_o`=3'b010 with `addr_o` bit 10 set and every other address bit clear.
- R4: From the cycle after the precharge until the normal value is loaded, `refresh_interval_o` equals FAST_INTERVAL (0xB).
- R5: During the fast phase, `cmd_o` is auto-refresh (3'b001) once every FAST_INTERVAL-1 = 10 cycles. The first refresh comes in the tenth cycle after the precharge. Every other cycle of the phase is NOP.
- R6: The fast phase lasts at least FAST_WAIT (80) cycles and issues at least MIN_REFS (8) refreshes. If a refresh falls in the cycle where the wait expires, the refresh is issued and the phase ends one cycle later (81 cycles with the defaults).
- R7: The fast phase is followed by one NOP cycle. At the end of that cycle `norm_interval_i` is loaded, and it appears on `refresh_interval_o` from the next cycle on. Later changes of the input have no effect.
- R8: The next cycle is a mode register set: `cmd_o`=3'b000 and `ba_o`=0. On a 32-bit bus the code 0x2 sits in `addr_o`[2:0] (`addr_o`=0x002). On a 16-bit bus the code 0x3 sits in `addr_o`[3:1] (`addr_o`=0x006).
- R9: `wide16_i` (1 = 16-bit bus, 0 = 32-bit bus) is sampled only in the first cycle after reset. Later changes do not alter the mode word.
- R10: From the cycle after the mode register set, `init_done_o` is 1 and stays 1, and `cmd_o` stays NOP.
- R11: Asserting reset at any point returns the outputs to the R1 values immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide16_i | input | 1 | Bus width select: 1 = 16-bit, 0 = 32-bit |
| norm_interval_i | input | REF_W | Normal-operation refresh interval |
| cmd_o | output | 3 | Command as {RAS#, CAS#, WE#} |
| addr_o | output | ADDR_W | SDRAM address lines |
| ba_o | output | BA_W | SDRAM bank address |
| refresh_interval_o | output | REF_W | Current refresh interval value |
| init_done_o | output | 1 | Initialization complete |

## Verification
The critical coincidence is between the refresh generator and the end of the fast phase. With the default settings, the eighth refresh falls in the same cycle in which the 80-cycle wait expires. That wait setting is therefore kept at its default in the bench, so that every run provokes the coincidence without special stimulus. The bench judges it against a cycle-by-cycle reference. The reference expects the auto-refresh in that cycle, one further NOP cycle still inside the fast phase, and only then the NOP cycle that loads the normal interval.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_NOP_WAIT,
    ST_PRECHARGE,
    ST_FAST_REF,
    ST_SET_REF,
    ST_MODE_SET,
    ST_DONE
  } init_state_t;

  // {RAS#, CAS#, WE#}
  localparam logic [2:0] CMD_NOP       = 3'b111;
  localparam logic [2:0] CMD_PRECHARGE = 3'b010;
  localparam logic [2:0] CMD_REFRESH   = 3'b001;
  localparam logic [2:0] CMD_MODE_SET  = 3'b000;

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int LIMIT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clear_i | (run_i & (cnt_q != LAST));
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LAST);

  // R6
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && run_i && !clear_i) |=> expired_o);
endmodule

// File: rtl/refresh_gen.sv
module refresh_gen #(
  parameter int INTERVAL = 11,
  parameter int MIN_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o,
  output logic enough_o
);
  localparam int PERIOD = INTERVAL - 1;
  localparam int CW     = $clog2(INTERVAL);
  localparam int RW     = $clog2(MIN_REFS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);
  localparam logic [RW-1:0] REF_SAT = RW'(MIN_REFS);

  logic [CW-1:0] down_q, down_d;
  logic [RW-1:0] refs_q, refs_d;
  logic          refs_en;

  assign tick_o   = run_i & (down_q == '0);
  assign enough_o = (refs_q == REF_SAT);

  always_comb begin
    if (!run_i || down_q == '0) down_d = RELOAD;
    else                        down_d = down_q - 1'b1;
    refs_en = !run_i | (tick_o & !enough_o);
    refs_d  = run_i ? refs_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) down_q <= RELOAD;
    else        down_q <= down_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       refs_q <= '0;
    else if (refs_en) refs_q <= refs_d;
  end

  // R5
  refresh_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/mode_word.sv
module mode_word #(
  parameter int ADDR_W  = 13,
  parameter int SHIFT16 = 1
) (
  input  logic              wide16_i,
  output logic [ADDR_W-1:0] mode_addr_o
);
  logic [2:0]        burst_code;
  logic [ADDR_W-1:0] base;

  always_comb begin
    burst_code  = wide16_i ? 3'd3 : 3'd2;
    base        = {{(ADDR_W-3){1'b0}}, burst_code};
    mode_addr_o = wide16_i ? (base << SHIFT16) : base;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_FREQ_MHZ  = 100,
  parameter int WAIT_US       = 200,
  parameter int FAST_INTERVAL = 11,
  parameter int FAST_WAIT     = 80,
  parameter int MIN_REFS      = 8,
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2,
  parameter int REF_W         = 16,
  parameter int AP_BIT        = 10,
  parameter int MODE_SHIFT16  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide16_i,
  input  logic [REF_W-1:0]  norm_interval_i,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [REF_W-1:0]  refresh_interval_o,
  output logic              init_done_o
);
  localparam int NOP_CYCLES = CLK_FREQ_MHZ * WAIT_US;
  localparam logic [REF_W-1:0]  FAST_VAL = REF_W'(FAST_INTERVAL);
  localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;

  init_state_t state_q, state_d;
  logic        wide_q, wide_en;
  logic [REF_W-1:0] intv_q, intv_d;
  logic        intv_en;
  logic        nop_expired, fast_expired, ref_tick, ref_enough;
  logic [ADDR_W-1:0] mode_addr;

  phase_timer #(.LIMIT(NOP_CYCLES)) u_nop_timer (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state_q != ST_NOP_WAIT),
    .run_i(state_q == ST_NOP_WAIT),
    .expired_o(nop_expired)
  );

  phase_timer #(.LIMIT(FAST_WAIT)) u_fast_timer (
    .clk(clk), .rst_n(rst_n),
    .clear_i(state_q != ST_FAST_REF),
    .run_i(state_q == ST_FAST_REF),
    .expired_o(fast_expired)
  );

  refresh_gen #(.INTERVAL(FAST_INTERVAL), .MIN_REFS(MIN_REFS)) u_refresh (
    .clk(clk), .rst_n(rst_n),
    .run_i(state_q == ST_FAST_REF),
    .tick_o(ref_tick),
    .enough_o(ref_enough)
  );

  mode_word #(.ADDR_W(ADDR_W), .SHIFT16(MODE_SHIFT16)) u_mode (
    .wide16_i(wide_q),
    .mode_addr_o(mode_addr)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:     state_d = ST_NOP_WAIT;
      ST_NOP_WAIT:  if (nop_expired) state_d = ST_PRECHARGE;
      ST_PRECHARGE: state_d = ST_FAST_REF;
      ST_FAST_REF:  if (fast_expired && ref_enough && !ref_tick) state_d = ST_SET_REF;
      ST_SET_REF:   state_d = ST_MODE_SET;
      ST_MODE_SET:  state_d = ST_DONE;
      ST_DONE:      state_d = ST_DONE;
      default:      state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  // width capture and refresh-interval register
  always_comb begin
    wide_en = (state_q == ST_RESET);
    intv_en = (state_q == ST_PRECHARGE) || (state_q == ST_SET_REF);
    intv_d  = (state_q == ST_PRECHARGE) ? FAST_VAL : norm_interval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wide_q <= 1'b0;
    else if (wide_en) wide_q <= wide16_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       intv_q <= '0;
    else if (intv_en) intv_q <= intv_d;
  end

  // command outputs
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    ba_o   = '0;
    unique case (state_q)
      ST_PRECHARGE: begin
        cmd_o  = CMD_PRECHARGE;
        addr_o = AP_MASK;
      end
      ST_FAST_REF:  if (ref_tick) cmd_o = CMD_REFRESH;
      ST_MODE_SET: begin
        cmd_o  = CMD_MODE_SET;
        addr_o = mode_addr;
      end
      default: ;
    endcase
  end

  assign refresh_interval_o = intv_q;
  assign init_done_o        = (state_q == ST_DONE);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |-> (cmd_o == CMD_NOP));
  // R3
  single_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRECHARGE) |=> (cmd_o != CMD_PRECHARGE));
  // R8
  mode_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MODE_SET) |=> init_done_o);
  // R4
  fast_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REFRESH) |-> (refresh_interval_o == FAST_VAL));
endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int MHZ = 4;
  localparam int US  = 5;
  localparam int N   = MHZ * US;
  localparam int FI  = 11;
  localparam int FW  = 80;
  localparam int MR  = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide16;
  logic [15:0] norm_in;
  logic [2:0]  cmd;
  logic [12:0] addr;
  logic [1:0]  ba;
  logic [15:0] intv;
  logic        done;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_init_seq #(.CLK_FREQ_MHZ(MHZ), .WAIT_US(US), .FAST_INTERVAL(FI),
                   .FAST_WAIT(FW), .MIN_REFS(MR)) u0 (
    .clk(clk), .rst_n(rst_n), .wide16_i(wide16), .norm_interval_i(norm_in),
    .cmd_o(cmd), .addr_o(addr), .ba_o(ba), .refresh_interval_o(intv),
    .init_done_o(done)
  );

  task automatic check(string req, int t, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=0x%0h expected=0x%0h", req, t, act, exp);
    end
  endtask

  function automatic int fast_len();
    int refs = 0;
    for (int i = 0; i < 10000; i++) begin
      bit tick = ((i % (FI - 1)) == (FI - 2));
      if (i >= FW - 1 && refs >= MR && !tick) return i + 1;
      if (tick) refs++;
    end
    return -1;
  endfunction

  function automatic logic [2:0] exp_cmd(int t, int L);
    if (t == N + 1) return 3'b010;
    if (t >= N + 2 && t <= N + 1 + L && (((t - N - 2) % (FI - 1)) == FI - 2))
      return 3'b001;
    if (t == N + L + 3) return 3'b000;
    return 3'b111;
  endfunction

  function automatic string phase_tag(int t, int L);
    if (t == 0) return "R1";
    if (t <= N) return "R2";
    if (t == N + 1) return "R3";
    if (t <= N + 1 + L) return "R5/R6";
    if (t == N + L + 2) return "R7";
    if (t == N + L + 3) return "R8/R9";
    return "R10";
  endfunction

  task automatic run_seq(bit w16, logic [15:0] norm, int abort_t);
    int L = fast_len();
    logic [12:0] eaddr;
    logic [15:0] eintv;
    rst_n   = 1'b0;
    wide16  = w16;
    norm_in = norm;
    repeat (2) @(negedge clk);
    check("R1 reset cmd", -1, cmd, 3'b111);
    check("R1 reset intv", -1, intv, 0);
    check("R1 reset done", -1, done, 0);
    rst_n = 1'b1;
    for (int t = 0; t <= N + L + 8; t++) begin
      eaddr = 0;
      if (t == N + 1) eaddr = 13'h400;
      if (t == N + L + 3) eaddr = w16 ? 13'h006 : 13'h002;
      if (t <= N + 1) eintv = 0;
      else if (t <= N + L + 2) eintv = 16'(FI);
      else eintv = norm;
      check({phase_tag(t, L), " cmd"}, t, cmd, exp_cmd(t, L));
      check({phase_tag(t, L), " addr"}, t, addr, eaddr);
      check("R8 ba", t, ba, 0);
      check((t <= N + L + 2) ? "R4 intv" : "R7 intv", t, intv, eintv);
      check("R10 done", t, done, (t >= N + L + 4) ? 1 : 0);
      if (t == 1) wide16 = ~w16;                  // R9 late change
      if (t == N + L + 3) norm_in = norm ^ 16'h5A5A; // R7 late change
      if (t == abort_t) begin
        #1 rst_n = 1'b0;
        #1;
        check("R11 cmd", t, cmd, 3'b111);
        check("R11 addr", t, addr, 0);
        check("R11 intv", t, intv, 0);
        check("R11 done", t, done, 0);
        return;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0123));
    rst_n = 1'b0; wide16 = 1'b0; norm_in = '0;
    run_seq(1'b0, 16'h0186, -1);
    run_seq(1'b1, 16'h0300, -1);
    run_seq(1'b1, 16'hFFFF, N + 40);
    for (int k = 0; k < 5; k++)
      run_seq(1'($urandom_range(0, 1)), 16'($urandom), -1);
    run_seq(1'b0, 16'h0001, N + L_dummy());
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic int L_dummy();
    return fast_len() + 3;
  endfunction

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule